// File: doc/BRIEF.md
# Two-Wire Key Event Register Target

This block is the serial-bus face of a key event recorder. It listens on a two-wire bus (clock and data, open-drain) and answers a 7-bit target address. The upper five bits of that address are fixed. The lowest two come from strap pins, so four of these blocks can share one bus. A host that addresses the block for reading always receives the same four-byte stream, in this order: an identity byte, the control byte, the key code of the oldest buffered event, and that event's duration byte. A host that addresses it for writing may send one byte, and that byte lands in the control register.

The bus lines are oversampled by a system clock that must run at least eight times faster than the bus clock. Each line passes through a two-flop synchroniser and an edge detector before any decision is made. The block pulls data low through an open-drain enable and never stretches the clock. Toward the event buffer it takes in the current key and duration words and an empty flag. It returns a peek pulse when it captures the word for sending and a pop pulse when the host has accepted the whole word. The pop is the only way the buffer advances, and it happens only when the host acknowledges the duration byte. If the host stops early or declines any byte, the next read returns the same word again.

Top module: `kri2c_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 01000 followed by the two strap pins (pin 1 then pin 0). For any other address it leaves data released for the rest of the transfer.
- R2: A read sends the identity byte, then the control byte, then the buffered key, then the buffered duration, each most significant bit first. A peek pulse marks the capture of the key and duration word.
- R3: A write stores the first data byte after the address into the control register and acknowledges it. Any further data byte in the same transfer is not acknowledged and changes nothing.
- R4: After reset, senseEnable is 1 and powerDown is 0. Bit 7 of the control register drives senseEnable and bit 6 drives powerDown, and both bits read back from the control byte.
- R5: In the control byte sent on a read, bit 5 is the buffer empty flag sampled when the byte is loaded, and bits 4 to 0 are zero. Writing bits 5 to 0 has no effect on what is read back.
- R6: When the host acknowledges the duration byte, bufPop is high for exactly one system clock.
- R7: If the host declines (NACK) any byte of a read, or ends the read before acknowledging the duration byte, no pop occurs and the next read returns the same key and duration.
- R8: A START (data falls while clock is high) begins address reception from any state, which includes a repeated START inside a transfer. A STOP (data rises while clock is high) returns the block to idle.
- R9: The block's acknowledge holds data low through the whole high phase of the ninth clock and releases it after that clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock level as seen on the wire |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls data low |
| addrPins | input | 2 | Strap pins forming the two low address bits |
| bufEmpty | input | 1 | Event buffer holds no unread word |
| bufKey | input | 8 | Key code of the word at the buffer read pointer |
| bufDur | input | 8 | Duration byte of the word at the read pointer |
| bufPop | output | 1 | One-cycle pulse: advance the buffer read pointer |
| bufPeek | output | 1 | One-cycle pulse: current word captured for sending |
| senseEnable | output | 1 | Control bit 7, enables the sense drive |
| powerDown | output | 1 | Control bit 6, requests power-down and full reset |

## Verification
The bench builds the block with the identity byte set to 0x5C instead of the zero default, so the first byte of every read can be told apart from the cleared control bits and the released bus. It keeps the default two-bit strap width, which makes the address sweep exhaustive: every strap setting is paired with all four in-family addresses and two outside ones. A sweep of control values then covers every combination of the two live control bits under noise in the dead bits. A small bench-side event buffer with a known word sequence lets acknowledge, decline and early-stop reads be told apart by which word comes back next.

// File: rtl/kri2c_pkg.sv
package kri2c_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_HOLD
  } busState_t;

  // Position in the fixed read stream; order is behaviour.
  typedef enum logic [1:0] {
    SEL_ID,
    SEL_CTRL,
    SEL_KEY,
    SEL_DUR
  } byteSel_t;

  typedef struct packed {
    logic     shiftIn;
    logic     shiftOut;
    logic     loadTx;
    byteSel_t loadSel;
    logic     ctrlWrite;
    logic     snapshot;
  } dpStrobe_t;

endpackage

// File: rtl/kri2c_bus_sync.sv
module kri2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;
  logic              sclLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/kri2c_dp.sv
module kri2c_dp
  import kri2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaLvl,
  input  logic              bufEmpty,
  input  logic [BYTE_W-1:0] bufKey,
  input  logic [BYTE_W-1:0] bufDur,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              senseEnable,
  output logic              powerDown
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] durSnap;
  logic              ctrlEn;
  logic              ctrlPd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
    end else if (strb.loadTx) begin
      case (strb.loadSel)
        SEL_ID:   shiftReg <= CHIP_ID;
        SEL_CTRL: shiftReg <= {ctrlEn, ctrlPd, bufEmpty, {(BYTE_W-3){1'b0}}};
        SEL_KEY:  shiftReg <= bufKey;
        default:  shiftReg <= durSnap;
      endcase
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
    end
  end

  // Duration is frozen with the key so both bytes describe one word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      durSnap <= '0;
    end else if (strb.snapshot) begin
      durSnap <= bufDur;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b1;
      ctrlPd <= 1'b0;
    end else if (strb.ctrlWrite) begin
      ctrlEn <= shiftReg[BYTE_W-1];
      ctrlPd <= shiftReg[BYTE_W-2];
    end
  end

  assign rxByte      = shiftReg;
  assign txBit       = shiftReg[BYTE_W-1];
  assign senseEnable = ctrlEn;
  assign powerDown   = ctrlPd;

  // R5: dead bits of the control byte are zero, bit 5 carries the empty flag
  p_ctrl_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && strb.loadSel == SEL_CTRL) |=>
      (shiftReg[BYTE_W-4:0] == '0 && shiftReg[BYTE_W-3] == $past(bufEmpty)));

  // R2: the shift register has one operation per cycle
  p_one_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftIn, strb.shiftOut, strb.loadTx}));

endmodule

// File: rtl/kri2c_ctrl.sv
module kri2c_ctrl
  import kri2c_pkg::*;
#(
  parameter int         PIN_W     = 2,
  parameter logic [6:0] ADDR_BASE = 7'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaLvl,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [PIN_W-1:0]  addrPins,
  output dpStrobe_t         strb,
  output logic              ackDrive,
  output logic              txActive,
  output logic              bufPop,
  output logic              bufPeek
);

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  busState_t             state, nState;
  logic [BIT_CNT_W-1:0]  bitCnt, nBitCnt;
  logic                  rxFull, nRxFull;
  byteSel_t              byteIdx, nByteIdx;
  logic                  isRead, nIsRead;
  logic                  ackSeen, nAckSeen;
  logic                  nAckDrive, nTxActive, nPop, nPeek;
  logic [6:0]            myAddr;

  assign myAddr = {ADDR_BASE[6:PIN_W], addrPins};

  always_comb begin
    nState    = state;
    nBitCnt   = bitCnt;
    nRxFull   = rxFull;
    nByteIdx  = byteIdx;
    nIsRead   = isRead;
    nAckSeen  = ackSeen;
    nAckDrive = ackDrive;
    nTxActive = txActive;
    nPop      = 1'b0;
    nPeek     = 1'b0;
    strb      = '0;

    if (stopDet) begin
      nState    = ST_IDLE;
      nAckDrive = 1'b0;
      nTxActive = 1'b0;
    end else if (startDet) begin
      nState    = ST_ADDR;
      nBitCnt   = '0;
      nRxFull   = 1'b0;
      nAckDrive = 1'b0;
      nTxActive = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_DATA: begin
          if (sclRise && !rxFull) begin
            strb.shiftIn = 1'b1;
            if (bitCnt == LAST_BIT) nRxFull = 1'b1;
            else                    nBitCnt = bitCnt + 1'b1;
          end else if (sclFall && rxFull) begin
            nRxFull = 1'b0;
            nBitCnt = '0;
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == myAddr) begin
                nAckDrive = 1'b1;
                nIsRead   = rxByte[0];
                nState    = ST_ADDR_ACK;
              end else begin
                nState = ST_HOLD;
              end
            end else begin
              strb.ctrlWrite = 1'b1;
              nAckDrive      = 1'b1;
              nState         = ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            nAckDrive = 1'b0;
            if (isRead) begin
              strb.loadTx  = 1'b1;
              strb.loadSel = SEL_ID;
              nByteIdx     = SEL_ID;
              nTxActive    = 1'b1;
              nState       = ST_RD_BYTE;
            end else begin
              nState = ST_WR_DATA;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            nAckDrive = 1'b0;
            nState    = ST_HOLD;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              nTxActive = 1'b0;
              nBitCnt   = '0;
              nState    = ST_RD_ACK;
            end else begin
              strb.shiftOut = 1'b1;
              nBitCnt       = bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            nAckSeen = !sdaLvl;
            if (!sdaLvl && byteIdx == SEL_DUR) nPop = 1'b1;
          end else if (sclFall) begin
            if (ackSeen && byteIdx != SEL_DUR) begin
              nByteIdx     = byteSel_t'(byteIdx + 2'd1);
              strb.loadTx  = 1'b1;
              strb.loadSel = byteSel_t'(byteIdx + 2'd1);
              nTxActive    = 1'b1;
              nState       = ST_RD_BYTE;
              if (byteIdx == SEL_CTRL) begin
                strb.snapshot = 1'b1;
                nPeek         = 1'b1;
              end
            end else begin
              nState = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rxFull   <= 1'b0;
      byteIdx  <= SEL_ID;
      isRead   <= 1'b0;
      ackSeen  <= 1'b0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      bufPop   <= 1'b0;
      bufPeek  <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nBitCnt;
      rxFull   <= nRxFull;
      byteIdx  <= nByteIdx;
      isRead   <= nIsRead;
      ackSeen  <= nAckSeen;
      ackDrive <= nAckDrive;
      txActive <= nTxActive;
      bufPop   <= nPop;
      bufPeek  <= nPeek;
    end
  end

  // R6: a pop follows only an observed acknowledge of the duration byte
  p_pop_on_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufPop |-> $past(state == ST_RD_ACK && byteIdx == SEL_DUR && sclRise && !sdaLvl));

  // R8: nothing is driven while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!ackDrive && !txActive));

  // R9: an acknowledge is released only on a clock fall or bus condition
  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackDrive) |-> $past(sclFall || startDet || stopDet));

  // R2: the peek pulse lands as the key byte goes out
  p_peek_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    bufPeek |-> (byteIdx == SEL_KEY && state == ST_RD_BYTE));

endmodule

// File: rtl/kri2c_target.sv
module kri2c_target
  import kri2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID     = 8'h00,
  parameter int                PIN_W       = 2,
  parameter logic [6:0]        ADDR_BASE   = 7'h20,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [PIN_W-1:0]  addrPins,
  input  logic              bufEmpty,
  input  logic [BYTE_W-1:0] bufKey,
  input  logic [BYTE_W-1:0] bufDur,
  output logic              bufPop,
  output logic              bufPeek,
  output logic              senseEnable,
  output logic              powerDown
);

  logic              sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic              ackDrive, txActive, txBit;
  logic [BYTE_W-1:0] rxByte;
  dpStrobe_t         strb;

  kri2c_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  kri2c_ctrl #(.PIN_W(PIN_W), .ADDR_BASE(ADDR_BASE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLvl(sdaLvl), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .addrPins(addrPins), .strb(strb),
    .ackDrive(ackDrive), .txActive(txActive),
    .bufPop(bufPop), .bufPeek(bufPeek)
  );

  kri2c_dp #(.CHIP_ID(CHIP_ID)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl),
    .bufEmpty(bufEmpty), .bufKey(bufKey), .bufDur(bufDur),
    .rxByte(rxByte), .txBit(txBit),
    .senseEnable(senseEnable), .powerDown(powerDown)
  );

  assign sdaDriveLow = ackDrive | (txActive & ~txBit);

endmodule

// File: tb/kri2c_target_tb.sv
module kri2c_target_tb_top;

  localparam logic [7:0] TB_ID = 8'h5C;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow;
  logic [1:0] addrPins = 2'd0;
  logic bufEmpty, bufPop, bufPeek, senseEnable, powerDown;
  logic [7:0] bufKey, bufDur;

  logic [7:0] mKey [8];
  logic [7:0] mDur [8];
  logic [3:0] wrCount = '0;
  logic [3:0] rdCount = '0;
  int popPulses = 0;
  int peekPulses = 0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [6:0] devAddr;

  always #4 clk = ~clk;

  assign sdaBus   = sdaM & ~sdaDriveLow;
  assign bufEmpty = (wrCount == rdCount);
  assign bufKey   = mKey[rdCount[2:0]];
  assign bufDur   = mDur[rdCount[2:0]];

  always @(posedge clk) begin
    if (bufPop) begin
      popPulses <= popPulses + 1;
      if (wrCount != rdCount) rdCount <= rdCount + 4'd1;
    end
    if (bufPeek) peekPulses <= peekPulses + 1;
  end

  kri2c_target #(.CHIP_ID(TB_ID)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .addrPins(addrPins),
    .bufEmpty(bufEmpty), .bufKey(bufKey), .bufDur(bufDur),
    .bufPop(bufPop), .bufPeek(bufPeek),
    .senseEnable(senseEnable), .powerDown(powerDown)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic bitCycle(input logic b, output logic r);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    r = sdaBus; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitCycle(v[i], r);
    bitCycle(1'b1, r);
    ack = ~r;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitCycle(1'b1, r);
      v = {v[6:0], r};
    end
    bitCycle(~ackIt, r);
  endtask

  task automatic readTxn(input logic ackLast, output logic [7:0] id,
                         output logic [7:0] c, output logic [7:0] k,
                         output logic [7:0] d);
    logic a;
    busStart();
    writeByte({devAddr, 1'b1}, a);
    readByte(1'b1, id);
    readByte(1'b1, c);
    readByte(1'b1, k);
    readByte(ackLast, d);
    busStop();
  endtask

  task automatic writeCtrl(input logic [7:0] v, output logic ack);
    logic a;
    busStart();
    writeByte({devAddr, 1'b0}, a);
    writeByte(v, ack);
    busStop();
  endtask

  task automatic pushWord(input logic [7:0] k, input logic [7:0] d);
    @(negedge clk);
    mKey[wrCount[2:0]] = k;
    mDur[wrCount[2:0]] = d;
    wrCount = wrCount + 4'd1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] id, c, k, d;
    logic a;
    int p0, k0;
    logic [6:0] cand [6];
    logic [7:0] wv [8];
    cand = '{7'h20, 7'h21, 7'h22, 7'h23, 7'h28, 7'h60};
    wv   = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h80, 8'h40, 8'hC0, 8'h3F};
    for (int i = 0; i < 8; i++) begin
      mKey[i] = 8'hFF;
      mDur[i] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R4: reset state
    chk("R4 senseEnable after reset", senseEnable, 1);
    chk("R4 powerDown after reset", powerDown, 0);
    chk("R9 bus released after reset", sdaDriveLow, 0);
    chk("R6 no pop after reset", bufPop, 0);

    // R1: exhaustive strap sweep against in-family and foreign addresses
    for (int p = 0; p < 4; p++) begin
      addrPins = 2'(p);
      waitQ();
      for (int j = 0; j < 6; j++) begin
        busStart();
        writeByte({cand[j], 1'b0}, a);
        chk($sformatf("R1 ack pins=%0d addr=0x%0h", p, cand[j]), a,
            int'(cand[j] == {5'b01000, 2'(p)}));
        chk("R1 released after address", sdaDriveLow, 0);
        busStop();
      end
    end

    addrPins = 2'd1;
    devAddr  = {5'b01000, 2'd1};
    waitQ();

    // R2 R5: read with empty buffer after reset
    p0 = popPulses; k0 = peekPulses;
    readTxn(1'b1, id, c, k, d);
    chk("R2 identity byte", id, TB_ID);
    chk("R5 control byte empty", c, 8'hA0);
    chk("R2 key byte", k, mKey[rdCount[2:0]]);
    chk("R2 duration byte", d, mDur[rdCount[2:0]]);
    chk("R6 one pop pulse", popPulses - p0, 1);
    chk("R2 one peek pulse", peekPulses - k0, 1);

    // R3 R4 R5: control write sweep
    for (int i = 0; i < 8; i++) begin
      writeCtrl(wv[i], a);
      chk("R3 control write acked", a, 1);
      chk("R4 senseEnable follows bit 7", senseEnable, wv[i][7]);
      chk("R4 powerDown follows bit 6", powerDown, wv[i][6]);
      readTxn(1'b0, id, c, k, d);
      chk($sformatf("R5 control readback after 0x%0h", wv[i]), c,
          {wv[i][7:6], 1'b1, 5'b0});
    end

    // R3 R9: second data byte refused, acknowledge released after ninth clock
    busStart();
    writeByte({devAddr, 1'b0}, a);
    chk("R9 address ack seen at ninth clock", a, 1);
    chk("R9 ack released after ninth fall", sdaDriveLow, 0);
    writeByte(8'h40, a);
    chk("R3 first data byte acked", a, 1);
    writeByte(8'hC0, a);
    chk("R3 second data byte refused", a, 0);
    busStop();
    chk("R3 second byte no effect on senseEnable", senseEnable, 0);
    chk("R3 second byte no effect on powerDown", powerDown, 1);
    writeCtrl(8'h80, a);

    // R6 R7: buffered words
    pushWord(8'h11, 8'h05);
    pushWord(8'h22, 8'h86);
    pushWord(8'h1D, 8'h7F);
    p0 = popPulses;
    readTxn(1'b1, id, c, k, d);
    chk("R5 control byte not empty", c, 8'h80);
    chk("R2 first key", k, 8'h11);
    chk("R2 first duration", d, 8'h05);
    chk("R6 pop on duration ack", popPulses - p0, 1);

    p0 = popPulses;
    readTxn(1'b0, id, c, k, d);
    chk("R2 second key", k, 8'h22);
    chk("R2 second duration", d, 8'h86);
    chk("R7 no pop on duration nack", popPulses - p0, 0);
    readTxn(1'b1, id, c, k, d);
    chk("R7 same key after nack", k, 8'h22);
    chk("R7 same duration after nack", d, 8'h86);
    chk("R6 pop after ack", popPulses - p0, 1);

    p0 = popPulses;
    busStart();
    writeByte({devAddr, 1'b1}, a);
    readByte(1'b1, id);
    readByte(1'b1, c);
    readByte(1'b0, k);
    busStop();
    chk("R7 key under nack", k, 8'h1D);
    chk("R7 no pop on key nack", popPulses - p0, 0);
    readTxn(1'b1, id, c, k, d);
    chk("R7 same key after early stop", k, 8'h1D);
    chk("R7 same duration after early stop", d, 8'h7F);
    chk("R6 final pop", popPulses - p0, 1);
    readTxn(1'b0, id, c, k, d);
    chk("R5 control byte empty again", c, 8'hA0);

    // R8: repeated start turns a write into a read
    busStart();
    writeByte({devAddr, 1'b0}, a);
    busRestart();
    writeByte({devAddr, 1'b1}, a);
    chk("R8 address acked after repeated start", a, 1);
    readByte(1'b0, id);
    busStop();
    chk("R8 identity after repeated start", id, TB_ID);
    chk("R8 idle after stop", sdaDriveLow, 0);
    chk("R8 control unchanged by aborted write", senseEnable, 1);

    finishRun();
  end

endmodule